// File: doc/BRIEF.md
# Zero-Page Effective Address Sequencer

This block walks the bus cycles of one memory-operand instruction for an 8-bit processor with a 16-bit address bus. It covers the short-address family: a one-byte page address, that address plus X or Y, a pointer fetched from the page at operand plus X, and a pointer fetched from the page at the operand with Y added afterwards. A full two-byte absolute form is included as a reference. For every clock of the instruction it presents one read address, beginning with the opcode address. The returning bytes feed back to form pointers and the final effective address.

A request is taken in the cycle `start` is high while the block is idle. That cycle is itself the opcode fetch. The index registers, the page base and the program counter are all sampled in that cycle. The page base supplies the high address byte of every in-page access, so the short page can be moved away from physical page 0. Every in-page sum wraps modulo 256. The memory read port is synchronous: an address presented in one cycle returns its byte in the next. `done` pulses in the cycle that carries the effective address on the bus.

Top module: `zp_ea_sequencer`

## Requirements
- R1: After reset `busValid` and `done` are low and `effAddr` is 0x0000.
- R2: Mode code 0 (page direct) takes 3 cycles with bus addresses PC, PC+1, {base, op}, where op is the byte read at PC+1. The effective address is {base, op}.
- R3: Mode codes 1 (plus X) and 2 (plus Y) take 4 cycles with addresses PC, PC+1, {base, op}, {base, (op+index) mod 256}. The last address is the effective address.
- R4: Mode code 5 (absolute) takes 4 cycles with addresses PC, PC+1, PC+2, {hi, lo}. Here lo is the byte at PC+1 and hi is the byte at PC+2, and the page base is not applied.
- R5: Mode code 3 (pre-indexed pointer) takes 6 cycles with addresses PC, PC+1, {base, op}, {base, p}, {base, (p+1) mod 256}, where p = (op+X) mod 256. These are followed by the effective address {byte at second pointer address, byte at first pointer address}.
- R6: Mode code 4 (post-indexed pointer) takes 5 cycles with addresses PC, PC+1, {base, op}, {base, (op+1) mod 256}, then pointer+Y, when the low pointer byte plus Y does not exceed 255.
- R7: In mode code 4, when the low pointer byte plus Y exceeds 255, one extra cycle is inserted before the effective address. That cycle reads {pointer high, (low+Y) mod 256}, and the effective address is (pointer+Y) mod 65536 with the carry in its high byte.
- R8: With a nonzero page base every in-page access and pointer fetch uses the base as its high address byte.
- R9: `done` is high for exactly one cycle, the final cycle, with `effAddr` equal to the bus address. `effAddr` keeps that value until the next `done`.
- R10: `start` is ignored while a request is in flight. A `start` in the cycle right after `done` is accepted, and that cycle presents its `pcIn`.
- R11: Mode codes 6 and 7 behave exactly as mode code 0.
- R12: X, Y, page base, mode and `pcIn` are sampled only in the accepting cycle. Later changes to them do not alter the running sequence.
- R13: `busValid` is high in every cycle of a sequence, including the index and carry-fix dummy reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 3 | Addressing mode code |
| pcIn | input | 16 | Address of the opcode byte |
| idxX | input | 8 | X index value |
| idxY | input | 8 | Y index value |
| pageBase | input | 8 | High address byte of the short page |
| memRdata | input | 8 | Read data, valid the cycle after its address |
| busAddr | output | 16 | Read address for this cycle |
| busValid | output | 1 | A read is issued this cycle |
| effAddr | output | 16 | Effective address, held after completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random requests across all eight mode codes mix operands, indices and bases. This separates wrapped in-page sums from sums that spill into the next page, and a base in the high byte from a forced zero. Directed cases place the operand or operand plus X at 0xFF, so a correct pointer-high fetch from offset 0x00 differs from a wrong one at the next page. They also pair Y = 0xFF with Y = 0, which tells the 6-cycle carry path from the 5-cycle path. Indices and base are scrambled after the accepting cycle, and `start` is held high through some requests, which exposes late sampling and restarts that should not occur.

// File: rtl/zp_seq_pkg.sv
package zp_seq_pkg;

  typedef enum logic [2:0] {
    MODE_ZP   = 3'd0,
    MODE_ZPX  = 3'd1,
    MODE_ZPY  = 3'd2,
    MODE_IZX  = 3'd3,
    MODE_IZY  = 3'd4,
    MODE_ABS  = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    SEL_PC,
    SEL_PAGE_OP,
    SEL_PAGE_PTR,
    SEL_PAGE_PTR1,
    SEL_FIX,
    SEL_ABS,
    SEL_PTR,
    SEL_PTR_Y
  } addr_sel_e;

  typedef struct packed {
    logic      loadReq;
    logic      pcInc;
    logic      useY;
    logic      capOp;
    logic      capLo;
    logic      capHi;
    logic      addIdx;
    logic      busValid;
    logic      done;
    addr_sel_e addrSel;
  } seq_ctl_t;

  // Reserved codes fall back to the plain page access.
  function automatic amode_e normMode(input logic [2:0] raw);
    case (raw)
      3'd1: return MODE_ZPX;
      3'd2: return MODE_ZPY;
      3'd3: return MODE_IZX;
      3'd4: return MODE_IZY;
      3'd5: return MODE_ABS;
      default: return MODE_ZP;
    endcase
  endfunction

  function automatic logic usesY(input amode_e m);
    return (m == MODE_ZPY) || (m == MODE_IZY);
  endfunction

  function automatic logic [2:0] cycleBudget(input amode_e m, input logic carried);
    case (m)
      MODE_ZPX, MODE_ZPY, MODE_ABS: return 3'd4;
      MODE_IZX:                     return 3'd6;
      MODE_IZY:                     return carried ? 3'd6 : 3'd5;
      default:                      return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/zp_seq_datapath.sv
module zp_seq_datapath
  import zp_seq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit USE_PAGE_BASE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_ctl_t              ctl,
  input  logic [2*DATA_W-1:0]   pcIn,
  input  logic [DATA_W-1:0]     idxX,
  input  logic [DATA_W-1:0]     idxY,
  input  logic [DATA_W-1:0]     pageBase,
  input  logic [DATA_W-1:0]     memRdata,
  output logic [2*DATA_W-1:0]   busAddr,
  output logic                  busValid,
  output logic [2*DATA_W-1:0]   effAddr,
  output logic                  idxCarry
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] effHold;
  logic [DATA_W-1:0] opReg, loReg, hiReg, idxReg, baseReg;
  logic [DATA_W-1:0] baseIn;

  generate
    if (USE_PAGE_BASE) begin : g_relocatable
      assign baseIn = pageBase;
    end else begin : g_fixedZero
      logic [DATA_W-1:0] unusedBase;
      assign unusedBase = pageBase;
      assign baseIn     = '0;
    end
  endgenerate

  // Bytes arriving this cycle are used before they are stored.
  logic [DATA_W-1:0] opLive, loLive, hiLive;
  assign opLive = ctl.capOp ? memRdata : opReg;
  assign loLive = ctl.capLo ? memRdata : loReg;
  assign hiLive = ctl.capHi ? memRdata : hiReg;

  logic [DATA_W-1:0] ptrIdx, ptrIdx1, fixLow;
  logic [ADDR_W-1:0] ptrFull, ptrPlusY;
  logic [DATA_W:0]   lowSum;

  assign ptrIdx   = opReg + (ctl.addIdx ? idxReg : '0);
  assign ptrIdx1  = ptrIdx + 1'b1;
  assign fixLow   = loReg + idxReg;
  assign ptrFull  = {hiLive, loReg};
  assign ptrPlusY = ptrFull + {{DATA_W{1'b0}}, idxReg};
  assign lowSum   = {1'b0, loLive} + {1'b0, idxReg};
  assign idxCarry = lowSum[DATA_W];

  always_comb begin
    case (ctl.addrSel)
      SEL_PC:        busAddr = ctl.loadReq ? pcIn : pcReg;
      SEL_PAGE_OP:   busAddr = {baseReg, opLive};
      SEL_PAGE_PTR:  busAddr = {baseReg, ptrIdx};
      SEL_PAGE_PTR1: busAddr = {baseReg, ptrIdx1};
      SEL_FIX:       busAddr = {hiLive, fixLow};
      SEL_ABS:       busAddr = {hiLive, opReg};
      SEL_PTR:       busAddr = ptrFull;
      default:       busAddr = ptrPlusY;
    endcase
  end

  assign busValid = ctl.busValid;
  assign effAddr  = ctl.done ? busAddr : effHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg   <= '0;
      opReg   <= '0;
      loReg   <= '0;
      hiReg   <= '0;
      idxReg  <= '0;
      baseReg <= '0;
      effHold <= '0;
    end else begin
      if (ctl.loadReq) begin
        pcReg   <= pcIn + 1'b1;
        idxReg  <= ctl.useY ? idxY : idxX;
        baseReg <= baseIn;
      end else if (ctl.pcInc) begin
        pcReg <= pcReg + 1'b1;
      end
      if (ctl.capOp) opReg <= memRdata;
      if (ctl.capLo) loReg <= memRdata;
      if (ctl.capHi) hiReg <= memRdata;
      if (ctl.done)  effHold <= busAddr;
    end
  end

  // R8: in-page selections carry the sampled base as high byte
  p_page_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrSel == SEL_PAGE_OP || ctl.addrSel == SEL_PAGE_PTR ||
     ctl.addrSel == SEL_PAGE_PTR1) |-> busAddr[ADDR_W-1:DATA_W] == baseReg);

  // R9: the effective address output does not move between completions
  p_eff_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.done |-> $stable(effAddr));

endmodule

// File: rtl/zp_seq_control.sv
module zp_seq_control
  import zp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  input  logic       idxCarry,
  output seq_ctl_t   ctl
);

  typedef enum logic [2:0] {
    S_IDLE, S_OPFETCH, S_ABSHI, S_DUMMY, S_PTRLO, S_PTRHI, S_FIX, S_EA
  } state_e;

  state_e state, stateNext;
  amode_e modeReg;
  amode_e modeNow;
  logic   carried, carriedNext;
  logic [2:0] cycleCnt;

  assign modeNow = normMode(mode);

  always_comb begin
    ctl         = '0;
    ctl.addrSel = SEL_PC;
    stateNext   = state;
    carriedNext = carried;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadReq  = 1'b1;
          ctl.useY     = usesY(modeNow);
          ctl.busValid = 1'b1;
          carriedNext  = 1'b0;
          stateNext    = S_OPFETCH;
        end
      end
      S_OPFETCH: begin
        ctl.busValid = 1'b1;
        ctl.pcInc    = 1'b1;
        case (modeReg)
          MODE_ABS:                     stateNext = S_ABSHI;
          MODE_ZPX, MODE_ZPY, MODE_IZX: stateNext = S_DUMMY;
          MODE_IZY:                     stateNext = S_PTRLO;
          default:                      stateNext = S_EA;
        endcase
      end
      S_ABSHI: begin
        ctl.busValid = 1'b1;
        ctl.capOp    = 1'b1;
        stateNext    = S_EA;
      end
      S_DUMMY: begin
        ctl.busValid = 1'b1;
        ctl.capOp    = 1'b1;
        ctl.addrSel  = SEL_PAGE_OP;
        stateNext    = (modeReg == MODE_IZX) ? S_PTRLO : S_EA;
      end
      S_PTRLO: begin
        ctl.busValid = 1'b1;
        if (modeReg == MODE_IZX) begin
          ctl.addIdx  = 1'b1;
          ctl.addrSel = SEL_PAGE_PTR;
        end else begin
          ctl.capOp   = 1'b1;
          ctl.addrSel = SEL_PAGE_OP;
        end
        stateNext = S_PTRHI;
      end
      S_PTRHI: begin
        ctl.busValid = 1'b1;
        ctl.capLo    = 1'b1;
        ctl.addIdx   = (modeReg == MODE_IZX);
        ctl.addrSel  = SEL_PAGE_PTR1;
        if (modeReg == MODE_IZY && idxCarry) begin
          carriedNext = 1'b1;
          stateNext   = S_FIX;
        end else begin
          stateNext   = S_EA;
        end
      end
      S_FIX: begin
        ctl.busValid = 1'b1;
        ctl.capHi    = 1'b1;
        ctl.addrSel  = SEL_FIX;
        stateNext    = S_EA;
      end
      default: begin
        ctl.busValid = 1'b1;
        ctl.done     = 1'b1;
        stateNext    = S_IDLE;
        case (modeReg)
          MODE_ABS: begin
            ctl.capHi   = 1'b1;
            ctl.addrSel = SEL_ABS;
          end
          MODE_ZPX, MODE_ZPY: begin
            ctl.addIdx  = 1'b1;
            ctl.addrSel = SEL_PAGE_PTR;
          end
          MODE_IZX: begin
            ctl.capHi   = 1'b1;
            ctl.addrSel = SEL_PTR;
          end
          MODE_IZY: begin
            ctl.capHi   = !carried;
            ctl.addrSel = SEL_PTR_Y;
          end
          default: begin
            ctl.capOp   = 1'b1;
            ctl.addrSel = SEL_PAGE_OP;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      modeReg  <= MODE_ZP;
      carried  <= 1'b0;
      cycleCnt <= '0;
    end else begin
      state   <= stateNext;
      carried <= carriedNext;
      if (state == S_IDLE) begin
        if (start) modeReg <= modeNow;
        cycleCnt <= start ? 3'd2 : 3'd0;
      end else begin
        cycleCnt <= cycleCnt + 3'd1;
      end
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !ctl.done);

  // R10: a request in flight is never restarted
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> (state != S_OPFETCH));

  // R2, R3, R4, R5, R6, R7: completion lands on the mode's cycle budget
  p_cycle_budget_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |-> cycleCnt == cycleBudget(modeReg, carried));

  // R13: a read is issued in every cycle of a running sequence
  p_bus_active_r13: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> ctl.busValid);

endmodule

// File: rtl/zp_ea_sequencer.sv
module zp_ea_sequencer
  import zp_seq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit USE_PAGE_BASE = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   idxX,
  input  logic [DATA_W-1:0]   idxY,
  input  logic [DATA_W-1:0]   pageBase,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [2*DATA_W-1:0] busAddr,
  output logic                busValid,
  output logic [2*DATA_W-1:0] effAddr,
  output logic                done
);

  seq_ctl_t ctl;
  logic     idxCarry;

  zp_seq_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mode     (mode),
    .idxCarry (idxCarry),
    .ctl      (ctl)
  );

  zp_seq_datapath #(
    .DATA_W        (DATA_W),
    .USE_PAGE_BASE (USE_PAGE_BASE)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pcIn     (pcIn),
    .idxX     (idxX),
    .idxY     (idxY),
    .pageBase (pageBase),
    .memRdata (memRdata),
    .busAddr  (busAddr),
    .busValid (busValid),
    .effAddr  (effAddr),
    .idxCarry (idxCarry)
  );

  assign done = ctl.done;

endmodule

// File: tb/tb_zp_ea_sequencer.sv
module tb_zp_ea_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] pcIn = 16'h0;
  logic [7:0]  idxX = 8'h0, idxY = 8'h0, pageBase = 8'h0;
  logic [7:0]  memRdata;
  logic [15:0] busAddr, effAddr;
  logic        busValid, done;

  int testCount = 0;
  int failCount = 0;

  logic [15:0] curPc = 16'hC000;
  logic [7:0]  opByte = 8'h0, hiByte = 8'h0;

  logic [15:0] expAddr [0:6];
  int          expLen;
  string       expTag;

  always #10 clk = ~clk;

  zp_ea_sequencer dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .pcIn(pcIn),
    .idxX(idxX), .idxY(idxY), .pageBase(pageBase), .memRdata(memRdata),
    .busAddr(busAddr), .busValid(busValid), .effAddr(effAddr), .done(done)
  );

  function automatic logic [7:0] hashByte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ (a[15:8] * 8'd13) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] memByte(input logic [15:0] a);
    if (a == curPc + 16'd1) return opByte;
    if (a == curPc + 16'd2) return hiByte;
    return hashByte(a);
  endfunction

  always_ff @(posedge clk) memRdata <= memByte(busAddr);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic buildExpect(input logic [2:0] m, input logic [15:0] pc,
                             input logic [7:0] op, input logic [7:0] hi,
                             input logic [7:0] x, input logic [7:0] y,
                             input logic [7:0] b);
    logic [7:0]  p, lo, ph;
    logic [15:0] ea;
    logic [8:0]  sum;
    expAddr[0] = pc;
    expAddr[1] = pc + 16'd1;
    case (m)
      3'd1, 3'd2: begin
        p = op + ((m == 3'd1) ? x : y);
        expAddr[2] = {b, op};
        expAddr[3] = {b, p};
        expLen = 4; expTag = "R3";
      end
      3'd3: begin
        p  = op + x;
        lo = hashByte({b, p});
        ph = hashByte({b, 8'(p + 8'd1)});
        expAddr[2] = {b, op};
        expAddr[3] = {b, p};
        expAddr[4] = {b, 8'(p + 8'd1)};
        expAddr[5] = {ph, lo};
        expLen = 6; expTag = "R5";
      end
      3'd4: begin
        lo  = hashByte({b, op});
        ph  = hashByte({b, 8'(op + 8'd1)});
        ea  = {ph, lo} + {8'h00, y};
        sum = {1'b0, lo} + {1'b0, y};
        expAddr[2] = {b, op};
        expAddr[3] = {b, 8'(op + 8'd1)};
        if (sum[8]) begin
          expAddr[4] = {ph, sum[7:0]};
          expAddr[5] = ea;
          expLen = 6; expTag = "R7";
        end else begin
          expAddr[4] = ea;
          expLen = 5; expTag = "R6";
        end
      end
      3'd5: begin
        expAddr[2] = pc + 16'd2;
        expAddr[3] = {hi, op};
        expLen = 4; expTag = "R4";
      end
      default: begin
        expAddr[2] = {b, op};
        expLen = 3;
        expTag = (m == 3'd0) ? "R2" : "R11";
      end
    endcase
  endtask

  // Entered at a falling edge; leaves at a falling edge with the block idle.
  task automatic runOne(input string tag, input logic [2:0] m, input logic [15:0] pc,
                        input logic [7:0] op, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y,
                        input logic [7:0] b, input bit holdStart);
    string useTag;
    logic [15:0] ea;
    buildExpect(m, pc, op, hi, x, y, b);
    useTag = (tag == "") ? expTag : tag;
    ea = expAddr[expLen-1];
    curPc = pc; opByte = op; hiByte = hi;
    start = 1'b1; mode = m; pcIn = pc; idxX = x; idxY = y; pageBase = b;
    for (int k = 0; k < expLen; k++) begin
      #5;
      chk(useTag, busAddr, expAddr[k]);
      chk("R13", {15'h0, busValid}, 16'h1);
      chk("R9", {15'h0, done}, {15'h0, k == expLen - 1});
      if (k == expLen - 1) chk("R9", effAddr, ea);
      @(negedge clk);
      if (k == 0) begin
        // R12: late changes on the request inputs must not matter
        start    = holdStart;
        mode     = 3'($urandom);
        pcIn     = 16'h8000 | 16'($urandom & 32'h0FF0);
        idxX     = 8'($urandom);
        idxY     = 8'($urandom);
        pageBase = 8'($urandom & 32'h7F);
      end
    end
    #5;
    if (!holdStart) begin
      chk("R9", {15'h0, done}, 16'h0);
      chk("R9", effAddr, ea);
      chk("R13", {15'h0, busValid}, 16'h0);
      @(negedge clk);
    end else begin
      // R10: a start held high is taken the cycle after completion
      chk("R10", busAddr, pcIn);
      chk("R10", {15'h0, busValid}, 16'h1);
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 10; w++) begin
        #5;
        if (done) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #5;
    chk("R1", {15'h0, busValid}, 16'h0);
    chk("R1", {15'h0, done}, 16'h0);
    chk("R1", effAddr, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #5;
    chk("R1", effAddr, 16'h0000);
    @(negedge clk);

    runOne("R2",  3'd0, 16'hC100, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    runOne("R2",  3'd0, 16'hC104, 8'hFF, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0);
    runOne("R3",  3'd1, 16'hC200, 8'hF0, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0);
    runOne("R3",  3'd2, 16'hC210, 8'h80, 8'h00, 8'h00, 8'h90, 8'h00, 1'b0);
    runOne("R4",  3'd5, 16'hC300, 8'h34, 8'h12, 8'h00, 8'h00, 8'h55, 1'b0);
    runOne("R5",  3'd3, 16'hC400, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'h00, 1'b0);
    runOne("R5",  3'd3, 16'hC410, 8'h10, 8'h00, 8'h05, 8'h00, 8'h00, 1'b0);
    runOne("",    3'd4, 16'hC500, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0);
    runOne("R6",  3'd4, 16'hC510, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    runOne("R8",  3'd0, 16'hC600, 8'h7A, 8'h00, 8'h00, 8'h00, 8'h21, 1'b0);
    runOne("R8",  3'd1, 16'hC610, 8'hF8, 8'h00, 8'h10, 8'h00, 8'h3E, 1'b0);
    runOne("R8",  3'd3, 16'hC620, 8'hFE, 8'h00, 8'h01, 8'h00, 8'h47, 1'b0);
    runOne("R8",  3'd4, 16'hC630, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h12, 1'b0);
    runOne("R11", 3'd6, 16'hC700, 8'h5C, 8'h00, 8'h33, 8'h44, 8'h00, 1'b0);
    runOne("R11", 3'd7, 16'hC710, 8'hA5, 8'h00, 8'h33, 8'h44, 8'h19, 1'b0);
    runOne("R12", 3'd4, 16'hC800, 8'h22, 8'h00, 8'h00, 8'hF0, 8'h05, 1'b0);
    runOne("R10", 3'd3, 16'hC900, 8'h09, 8'h00, 8'h07, 8'h00, 8'h02, 1'b1);
    runOne("R10", 3'd0, 16'hC910, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);

    for (int i = 0; i < 400; i++) begin
      runOne("", 3'($urandom), 16'hC000 | 16'($urandom & 32'h0FF0),
             8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             8'(($urandom & 32'h3) == 0 ? 0 : ($urandom & 32'h7F)),
             ($urandom & 32'h7) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule